// File: doc/BRIEF.md
# Arithmetic Status Flag Register

This block holds the 8-bit status word that sits next to an 8-bit arithmetic unit. Each cycle it takes the two operands, a carry-in and an operation code. It computes the carry chain of the sum or difference itself and registers carry, half-carry and signed overflow. A divide operation passes only its divisor, and the block flags a zero divisor. Dedicated operations force the carry flag to one or to zero.

The parity bit is not stored. It is derived combinationally from the accumulator value on `acc_i`, so it follows that register at every moment. Software can overwrite the other seven bits through a write port, and the two bank-select bits are brought out separately to steer register-file addressing.

The status word is laid out from bit 7 down to bit 0 as follows:
- carry
- half-carry
- user flag F0
- bank select high
- bank select low
- overflow
- spare user bit
- parity

Top module: `psw_flag_unit`

## Requirements
- R1: While reset is held and after it is released, `psw_o[7:1]` is 0 and `bank_o` is 0; `psw_o[0]` still reflects the accumulator.
- R2: Op code 1 (add) sets the carry flag (`psw_o[7]`) to the carry out of bit 7 of A+B, ignoring `cin_i`. Op code 2 (add with carry) uses A+B+`cin_i`. The flag is visible one clock after the operation.
- R3: Both add ops set the half-carry flag (`psw_o[6]`) when the low nibbles plus carry-in exceed 15, and clear it otherwise. Op code 3 (subtract with borrow) leaves it unchanged.
- R4: Op code 3 sets the carry flag when A-B-`cin_i` is negative (a borrow), and clears it otherwise.
- R5: For op codes 1, 2 and 3, the overflow flag (`psw_o[2]`) is set when the signed result lies outside -128..127, and cleared otherwise.
- R6: Op code 4 (divide) sets the overflow flag when `opnd_b_i` is zero and clears it otherwise. Carry and half-carry are unchanged.
- R7: Op code 5 sets the carry flag and op code 6 clears it. Other flags are unchanged.
- R8: `psw_o[0]` equals the XOR of all bits of `acc_i`, combinationally, and software writes never alter it.
- R9: With op code 0 (no operation), `sw_we_i` loads `sw_data_i[7:1]` into `psw_o[7:1]` on the next clock. `bank_o` equals `psw_o[4:3]`.
- R10: When a software write and an arithmetic op occur in the same cycle, the op's result wins for the flags that op affects. The remaining bits take the written value.
- R11: With op code 0 and no write, `psw_o[7:1]` holds its value whatever the operands are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| op_i | input | 3 | Operation code (0 none, 1 add, 2 add with carry, 3 subtract with borrow, 4 divide, 5 set carry, 6 clear carry) |
| opnd_a_i | input | W | First operand / minuend |
| opnd_b_i | input | W | Second operand / subtrahend / divisor |
| cin_i | input | 1 | Carry or borrow in |
| acc_i | input | W | Current accumulator value |
| sw_we_i | input | 1 | Software write strobe for the status word |
| sw_data_i | input | 8 | Software write data |
| psw_o | output | 8 | Status word |
| bank_o | output | 2 | Register bank select |

## Verification
The add operation is swept over every operand pair with a carry-in that toggles. This separates the ignored carry-in from the real one and reaches every nibble-carry and sign-crossing combination. Add with carry and subtract with borrow are swept over all first operands against a strided set of second operands, with both carry-in values. The subtract sweep also shows that half-carry keeps the value left by the last add. Separate short sequences cover the following:
- zero and non-zero divisors
- forced carry
- every bank value
- held state under changing operands
- a write colliding with an operation

// File: rtl/psw_pkg.sv
package psw_pkg;

    typedef enum logic [2:0] {
        OP_NOP  = 3'd0,
        OP_ADD  = 3'd1,
        OP_ADDC = 3'd2,
        OP_SUBB = 3'd3,
        OP_DIV  = 3'd4,
        OP_SETC = 3'd5,
        OP_CLRC = 3'd6
    } psw_op_e;

    // Stored part of the status word, bit 7 down to bit 1.
    typedef struct packed {
        logic       cy;
        logic       ac;
        logic       f0;
        logic [1:0] bank;
        logic       ov;
        logic       spare;
    } psw_flags_t;

    localparam int STATUS_W = 8;

endpackage

// File: rtl/psw_addsub.sv
module psw_addsub #(
    parameter int W = 8
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         cin_i,
    input  logic         sub_i,
    output logic         carry_o,
    output logic         half_o,
    output logic         ovf_o
);

    localparam int HALF_POS = 4;

    logic [W-1:0] b_eff;
    logic [W:0]   chain;

    // Subtraction is a + ~b + ~borrow_in.
    assign b_eff    = sub_i ? ~b_i : b_i;
    assign chain[0] = sub_i ? ~cin_i : cin_i;

    for (genvar i = 0; i < W; i++) begin : g_ripple
        assign chain[i+1] = (a_i[i] & b_eff[i]) | (chain[i] & (a_i[i] ^ b_eff[i]));
    end

    // A subtract reports a borrow, i.e. no carry out of the top bit.
    assign carry_o = sub_i ? ~chain[W] : chain[W];
    assign half_o  = chain[HALF_POS];
    assign ovf_o   = chain[W] ^ chain[W-1];

endmodule

// File: rtl/psw_parity.sv
module psw_parity #(
    parameter int W = 8
) (
    input  logic [W-1:0] acc_i,
    output logic         odd_o
);

    logic [W:0] acc_chain;

    assign acc_chain[0] = 1'b0;

    for (genvar i = 0; i < W; i++) begin : g_xor
        assign acc_chain[i+1] = acc_chain[i] ^ acc_i[i];
    end

    assign odd_o = acc_chain[W];

endmodule

// File: rtl/psw_flag_unit.sv
module psw_flag_unit
    import psw_pkg::*;
#(
    parameter int W = 8
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic [2:0]          op_i,
    input  logic [W-1:0]        opnd_a_i,
    input  logic [W-1:0]        opnd_b_i,
    input  logic                cin_i,
    input  logic [W-1:0]        acc_i,
    input  logic                sw_we_i,
    input  logic [STATUS_W-1:0] sw_data_i,
    output logic [STATUS_W-1:0] psw_o,
    output logic [1:0]          bank_o
);

    psw_op_e    op;
    psw_flags_t flags_q;
    psw_flags_t flags_d;
    logic       cin_eff;
    logic       is_sub;
    logic       au_carry;
    logic       au_half;
    logic       au_ovf;
    logic       parity;
    logic       div_zero;

    assign op       = psw_op_e'(op_i);
    assign is_sub   = (op == OP_SUBB);
    assign cin_eff  = (op == OP_ADD) ? 1'b0 : cin_i;
    assign div_zero = (opnd_b_i == '0);

    psw_addsub #(.W(W)) addsub_i (
        .a_i     (opnd_a_i),
        .b_i     (opnd_b_i),
        .cin_i   (cin_eff),
        .sub_i   (is_sub),
        .carry_o (au_carry),
        .half_o  (au_half),
        .ovf_o   (au_ovf)
    );

    psw_parity #(.W(W)) parity_i (
        .acc_i (acc_i),
        .odd_o (parity)
    );

    // Next-state: software write first, arithmetic result overrides it.
    always_comb begin
        flags_d = flags_q;
        if (sw_we_i) begin
            flags_d = psw_flags_t'(sw_data_i[STATUS_W-1:1]);
        end
        case (op)
            OP_ADD, OP_ADDC: begin
                flags_d.cy = au_carry;
                flags_d.ac = au_half;
                flags_d.ov = au_ovf;
            end
            OP_SUBB: begin
                flags_d.cy = au_carry;
                flags_d.ov = au_ovf;
            end
            OP_DIV:  flags_d.ov = div_zero;
            OP_SETC: flags_d.cy = 1'b1;
            OP_CLRC: flags_d.cy = 1'b0;
            default: ;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            flags_q <= '0;
        end else begin
            flags_q <= flags_d;
        end
    end

    assign psw_o  = {flags_q, parity};
    assign bank_o = flags_q.bank;

    AST_SETC_FORCES_CY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (op_i == 3'd5) |=> psw_o[7]);  // R7
    AST_CLRC_CLEARS_CY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (op_i == 3'd6) |=> !psw_o[7]);  // R7
    AST_DIV_ZERO_OV: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (op_i == 3'd4) |=> (psw_o[2] == ($past(opnd_b_i) == '0)));  // R6
    AST_DIV_KEEPS_CARRIES: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (op_i == 3'd4 && !sw_we_i) |=> $stable(psw_o[7:6]));  // R6
    AST_SUB_KEEPS_AC: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (op_i == 3'd3 && !sw_we_i) |=> $stable(psw_o[6]));  // R3
    AST_IDLE_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (op_i == 3'd0 && !sw_we_i) |=> $stable(psw_o[7:1]));  // R11
    AST_SW_LOADS_BANK: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (op_i == 3'd0 && sw_we_i) |=> (bank_o == $past(sw_data_i[4:3])));  // R9

endmodule

// File: tb/psw_flag_unit_tb.sv
module psw_flag_unit_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int W          = 8;
    localparam int WATCHDOG   = 190000;

    logic         clk_i = 1'b0;
    logic         rst_ni;
    logic [2:0]   op_i;
    logic [W-1:0] opnd_a_i;
    logic [W-1:0] opnd_b_i;
    logic         cin_i;
    logic [W-1:0] acc_i;
    logic         sw_we_i;
    logic [7:0]   sw_data_i;
    logic [7:0]   psw_o;
    logic [1:0]   bank_o;

    int  n_vec  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;

    // Expected stored bits, maintained from the requirements.
    logic e_cy, e_ac, e_f0, e_ov, e_sp;
    logic [1:0] e_bank;

    always #(CLK_PERIOD/2) clk_i = ~clk_i;

    psw_flag_unit #(.W(W)) dut_i (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .op_i      (op_i),
        .opnd_a_i  (opnd_a_i),
        .opnd_b_i  (opnd_b_i),
        .cin_i     (cin_i),
        .acc_i     (acc_i),
        .sw_we_i   (sw_we_i),
        .sw_data_i (sw_data_i),
        .psw_o     (psw_o),
        .bank_o    (bank_o)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h (op %0d a %02h b %02h cin %0b)",
                     req, act, exp, op_i, opnd_a_i, opnd_b_i, cin_i);
        end
    endtask

    function automatic logic [7:0] exp_word();
        return {e_cy, e_ac, e_f0, e_bank, e_ov, e_sp, ^acc_i};
    endfunction

    // Apply one vector at a falling edge; the result is registered at the
    // following rising edge and sampled at the next falling edge.
    task automatic step(input logic [2:0] op, input int a, input int b, input logic c,
                        input int acc, input logic we, input logic [7:0] wd);
        op_i      = op;
        opnd_a_i  = a[7:0];
        opnd_b_i  = b[7:0];
        cin_i     = c;
        acc_i     = acc[7:0];
        sw_we_i   = we;
        sw_data_i = wd;
        @(negedge clk_i);
    endtask

    function automatic int sgn(input int v);
        return (v > 127) ? v - 256 : v;
    endfunction

    task automatic add_vec(input logic [2:0] op, input int a, input int b, input logic c);
        int ci;
        int s;
        int ss;
        ci = (op == 3'd2) ? int'(c) : 0;
        s  = a + b + ci;
        ss = sgn(a) + sgn(b) + ci;
        step(op, a, b, c, s, 1'b0, 8'h00);
        e_cy = (s > 255);
        e_ac = (((a % 16) + (b % 16) + ci) > 15);
        e_ov = (ss > 127) || (ss < -128);
        chk("R2 carry", {7'd0, psw_o[7]}, {7'd0, e_cy});
        chk("R3 half-carry", {7'd0, psw_o[6]}, {7'd0, e_ac});
        chk("R5 overflow", {7'd0, psw_o[2]}, {7'd0, e_ov});
        chk("R8 parity/held bits", psw_o, exp_word());
    endtask

    task automatic sub_vec(input int a, input int b, input logic c);
        int d;
        int sd;
        d  = a - b - int'(c);
        sd = sgn(a) - sgn(b) - int'(c);
        step(3'd3, a, b, c, d & 255, 1'b0, 8'h00);
        e_cy = (d < 0);
        e_ov = (sd > 127) || (sd < -128);
        chk("R4 borrow", {7'd0, psw_o[7]}, {7'd0, e_cy});
        chk("R5 overflow", {7'd0, psw_o[2]}, {7'd0, e_ov});
        chk("R3 half-carry held", {7'd0, psw_o[6]}, {7'd0, e_ac});
        chk("R8 parity/held bits", psw_o, exp_word());
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk_i);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

    initial begin
        rst_ni = 1'b0;
        op_i = 3'd0; opnd_a_i = '0; opnd_b_i = '0; cin_i = 1'b0;
        acc_i = 8'h07; sw_we_i = 1'b0; sw_data_i = 8'h00;
        {e_cy, e_ac, e_f0, e_bank, e_ov, e_sp} = '0;
        repeat (3) @(negedge clk_i);
        chk("R1 reset word", psw_o, 8'h01);
        chk("R1 reset bank", {6'd0, bank_o}, 8'h00);
        rst_ni = 1'b1;
        step(3'd0, 0, 0, 1'b0, 8'h06, 1'b0, 8'h00);
        chk("R1 after release", psw_o, 8'h00);

        // R9: software write, parity untouched by bit 0 of the data
        step(3'd0, 0, 0, 1'b0, 8'h03, 1'b1, 8'hFF);
        {e_cy, e_ac, e_f0, e_bank, e_ov, e_sp} = 7'h7F;
        chk("R9 write all", psw_o, 8'hFE);
        chk("R8 write ignores parity", {7'd0, psw_o[0]}, 8'h00);
        for (int k = 0; k < 4; k++) begin
            step(3'd0, 0, 0, 1'b0, k, 1'b1, 8'(k << 3));
            {e_cy, e_ac, e_f0, e_bank, e_ov, e_sp} = 7'(k << 2);
            chk("R9 bank", {6'd0, bank_o}, 8'(k));
            chk("R9 word", psw_o, exp_word());
        end

        // R7: forced carry
        step(3'd5, 0, 0, 1'b0, 0, 1'b0, 8'h00);
        e_cy = 1'b1;
        chk("R7 set carry", psw_o, exp_word());
        step(3'd6, 0, 0, 1'b0, 0, 1'b0, 8'h00);
        e_cy = 1'b0;
        chk("R7 clear carry", psw_o, exp_word());

        // R6: divide, carry forced high first to show it is kept
        step(3'd5, 0, 0, 1'b0, 0, 1'b0, 8'h00);
        e_cy = 1'b1;
        step(3'd4, 8'h40, 0, 1'b0, 0, 1'b0, 8'h00);
        e_ov = 1'b1;
        chk("R6 divide by zero", psw_o, exp_word());
        step(3'd4, 8'h40, 5, 1'b0, 0, 1'b0, 8'h00);
        e_ov = 1'b0;
        chk("R6 nonzero divisor", psw_o, exp_word());

        // User bits set so the sweeps also show they are held.
        step(3'd0, 0, 0, 1'b0, 0, 1'b1, 8'h3A);
        {e_cy, e_ac, e_f0, e_bank, e_ov, e_sp} = 7'h1D;
        chk("R9 user bits", psw_o, exp_word());

        // R2/R3/R5: exhaustive add; carry-in toggles and must be ignored
        for (int a = 0; a < 256; a++) begin
            for (int b = 0; b < 256; b++) begin
                add_vec(3'd1, a, b, logic'((a ^ (b >> 1)) & 1));
            end
        end
        // R2/R3/R5: add with carry, strided second operand
        for (int a = 0; a < 256; a++) begin
            for (int b = 0; b < 256; b += 7) begin
                add_vec(3'd2, a, b, logic'(b & 1));
            end
        end
        // R4/R5/R3: subtract with borrow
        for (int a = 0; a < 256; a++) begin
            for (int b = 0; b < 256; b += 3) begin
                sub_vec(a, b, logic'((a >> 1) & 1));
            end
        end

        // R11: idle with changing operands
        for (int k = 0; k < 8; k++) begin
            step(3'd0, k * 37, 255 - k, logic'(k & 1), k * 29, 1'b0, 8'hFF);
            chk("R11 hold", psw_o, exp_word());
        end

        // R10: collision of write and operation
        step(3'd1, 0, 0, 1'b0, 0, 1'b1, 8'hFF);
        e_cy = 1'b0; e_ac = 1'b0; e_ov = 1'b0;
        e_f0 = 1'b1; e_bank = 2'b11; e_sp = 1'b1;
        chk("R10 add beats write", psw_o, exp_word());
        step(3'd5, 0, 0, 1'b0, 1, 1'b1, 8'h00);
        {e_cy, e_ac, e_f0, e_bank, e_ov, e_sp} = 7'h40;
        chk("R10 set carry beats write", psw_o, exp_word());
        step(3'd4, 0, 0, 1'b0, 0, 1'b1, 8'h00);
        {e_cy, e_ac, e_f0, e_bank, e_ov, e_sp} = 7'h02;
        chk("R10 divide beats write", psw_o, exp_word());

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

endmodule